// File: doc/BRIEF.md
# Shared-Comparator Merge Tree Level

This block is one stage of a hardware merge-sort tree. It owns `N_PAIRS` pairs of input record queues and one output record queue per pair. Each record is a key together with an end-of-run marker. Every input of a pair carries a sequence of runs whose keys ascend. The level interleaves each pair's two runs into one ascending run on that pair's output.

All pairs share a single key comparator, so the level moves at most one record per clock across all of its pairs. A round-robin scheduler chooses which pair uses the comparator. A pair can be chosen when its output queue has a free slot and the input heads it needs are present. The scheduler comes in two forms, picked by a parameter. The combinational form selects and issues in the same cycle and suits narrow levels. The registered form spends one cycle on selection and then confirms eligibility again at issue, which shortens the logic path in wide levels.

Input and output streams use valid/ready handshakes. Input `2p` is the first side of pair `p`, input `2p+1` is the second side, and output `p` is that pair's merged stream.

Top module: `merge_level`

## Requirements
- R1: While reset is asserted, every `in_ready` bit is 1 and every `out_valid` bit is 0.
- R2: Each input owns a queue of `FIFO_DEPTH` records. `in_ready` is 0 exactly when that queue is full, and records leave the queue in arrival order.
- R3: Each pair owns an output queue of `FIFO_DEPTH` records. `out_valid` is 1 while that queue is not empty, `out_key`/`out_last` show its oldest record, and a record is removed on `out_valid && out_ready`.
- R4: In merge mode, a pair forwards the head with the smaller key, compared as unsigned. Only that record is removed from its input.
- R5: When the two heads of a pair hold equal keys, the record on the first input (index `2p`) is forwarded.
- R6: Once one side of a pair has forwarded its end-of-run record, the other side's records are forwarded without comparison up to and including its own end-of-run record. The pair then returns to merge mode.
- R7: `out_last` is 1 only on the record that closes the second of the two runs being merged.
- R8: The level moves at most one record per cycle in total. A pair is served only when its output queue has room and the input heads required by its mode are present. Every input record reaches its pair's output exactly once.
- R9: Among eligible pairs, the grant goes to the first one found in round-robin order, starting just after the last pair selected. After reset the search starts at pair 0.
- R10: With `PIPE_SCHED=0`, a pair that is eligible in cycle t is served at the edge ending cycle t. With `PIPE_SCHED=1`, the pair is selected in cycle t and served at the edge ending cycle t+1.
- R11: With `PIPE_SCHED=1`, a selected pair that is no longer eligible when its issue cycle comes is skipped. No output queue ever receives a record while it is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2*N_PAIRS | Record offered on each input |
| in_ready | output | 2*N_PAIRS | Input queue has a free slot |
| in_key | input | 2*N_PAIRS*KEY_W | Key of each input's record; input i occupies bits [i*KEY_W +: KEY_W] |
| in_last | input | 2*N_PAIRS | End-of-run marker of each input's record |
| out_valid | output | N_PAIRS | Pair output queue holds a record |
| out_ready | input | N_PAIRS | Consumer takes the pair's output record |
| out_key | output | N_PAIRS*KEY_W | Key of each pair's output record; pair p occupies bits [p*KEY_W +: KEY_W] |
| out_last | output | N_PAIRS | End of a merged run on the pair's output |

## Verification
The assertions assume that the producer presents each input's runs in ascending key order. They also assume that both sides of a pair eventually supply the same number of runs, because a pair in merge mode waits for both heads. The stimulus builds every input stream from non-decreasing keys and gives both sides of a pair the same run count. It varies run lengths, valid gaps and consumer stalls, places one side's keys near the top of the key range against low keys on the other side, and crowds keys into a narrow range so that ties appear often. Both scheduler forms are driven with the same stream contents.

// File: rtl/mtl_pkg.sv
package mtl_pkg;

  // Merge state kept per pair.
  typedef enum logic [1:0] {
    PM_MERGE   = 2'd0,  // both sides still inside their current run
    PM_A_ENDED = 2'd1,  // first side has closed its run, second side drains
    PM_B_ENDED = 2'd2   // second side has closed its run, first side drains
  } pair_mode_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mtl_fifo.sv
module mtl_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         not_full,
  output logic         not_empty,
  output logic [W-1:0] head
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage needs no reset; the count qualifies every read.
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end

  assign not_full  = (cnt_q != CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign head      = mem_q[rd_q];

  // R2
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> not_full);
  // R2
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);

endmodule

// File: rtl/mtl_rr_pick.sv
module mtl_rr_pick #(
  parameter int N  = 4,
  parameter int IW = mtl_pkg::idx_width(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Search starts just after the previous selection and wraps around.
  always_comb begin
    int c;
    found = 1'b0;
    idx   = '0;
    for (int i = 1; i <= N; i++) begin
      c = (int'(last) + i) % N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

endmodule

// File: rtl/mtl_sched.sv
module mtl_sched #(
  parameter int N          = 4,
  parameter bit PIPE_SCHED = 1'b0,
  parameter int IW         = mtl_pkg::idx_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic          fire,
  output logic [IW-1:0] fire_idx
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          pick_v;
  logic [IW-1:0] pick_idx;

  mtl_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req   (elig),
    .last  (ptr_q),
    .found (pick_v),
    .idx   (pick_idx)
  );

  always_comb ptr_d = pick_v ? pick_idx : ptr_q;

  // Reset to the last pair so that pair 0 is searched first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IW'(N - 1);
    else        ptr_q <= ptr_d;
  end

  generate
    if (PIPE_SCHED) begin : g_pipe
      logic          sel_v_q, sel_v_d;
      logic [IW-1:0] sel_idx_q, sel_idx_d;

      always_comb begin
        sel_v_d   = pick_v;
        sel_idx_d = pick_v ? pick_idx : sel_idx_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sel_v_q   <= 1'b0;
          sel_idx_q <= '0;
        end else begin
          sel_v_q   <= sel_v_d;
          sel_idx_q <= sel_idx_d;
        end
      end

      // The registered choice is confirmed against current eligibility.
      assign fire     = sel_v_q && elig[sel_idx_q];
      assign fire_idx = sel_idx_q;
    end else begin : g_comb
      assign fire     = pick_v;
      assign fire_idx = pick_idx;
    end
  endgenerate

endmodule

// File: rtl/mtl_merge_core.sv
module mtl_merge_core import mtl_pkg::*; #(
  parameter int N_PAIRS = 4,
  parameter int KEY_W   = 32,
  parameter int IW      = mtl_pkg::idx_width(N_PAIRS),
  parameter int REC_W   = KEY_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [IW-1:0]      fire_idx,
  input  logic [REC_W-1:0]   a_head [N_PAIRS],
  input  logic [REC_W-1:0]   b_head [N_PAIRS],
  input  logic [N_PAIRS-1:0] a_ne,
  input  logic [N_PAIRS-1:0] b_ne,
  input  logic [N_PAIRS-1:0] o_room,
  output logic [N_PAIRS-1:0] elig,
  output logic [N_PAIRS-1:0] pop_a,
  output logic [N_PAIRS-1:0] pop_b,
  output logic [N_PAIRS-1:0] o_push,
  output logic [REC_W-1:0]   push_rec
);

  pair_mode_e mode_q [N_PAIRS];
  pair_mode_e mode_d [N_PAIRS];

  logic [REC_W-1:0] sel_a, sel_b, win;
  pair_mode_e       sel_mode, win_mode;
  logic             take_a;

  // Eligibility: room downstream and the heads the mode needs.
  always_comb begin
    for (int p = 0; p < N_PAIRS; p++) begin
      case (mode_q[p])
        PM_MERGE:   elig[p] = o_room[p] && a_ne[p] && b_ne[p];
        PM_A_ENDED: elig[p] = o_room[p] && b_ne[p];
        PM_B_ENDED: elig[p] = o_room[p] && a_ne[p];
        default:    elig[p] = 1'b0;
      endcase
    end
  end

  // The one comparator of the level, fed through the pair select mux.
  always_comb begin
    sel_a    = a_head[fire_idx];
    sel_b    = b_head[fire_idx];
    sel_mode = mode_q[fire_idx];
    case (sel_mode)
      PM_A_ENDED: take_a = 1'b0;
      PM_B_ENDED: take_a = 1'b1;
      default:    take_a = (sel_a[KEY_W-1:0] <= sel_b[KEY_W-1:0]);
    endcase
    win      = take_a ? sel_a : sel_b;
    push_rec = {win[KEY_W] && (sel_mode != PM_MERGE), win[KEY_W-1:0]};
    if (!win[KEY_W])                win_mode = sel_mode;
    else if (sel_mode != PM_MERGE)  win_mode = PM_MERGE;
    else if (take_a)                win_mode = PM_A_ENDED;
    else                            win_mode = PM_B_ENDED;
  end

  always_comb begin
    for (int p = 0; p < N_PAIRS; p++) begin
      o_push[p] = fire && (fire_idx == IW'(p));
      pop_a[p]  = o_push[p] && take_a;
      pop_b[p]  = o_push[p] && !take_a;
      mode_d[p] = o_push[p] ? win_mode : mode_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PAIRS; p++) mode_q[p] <= PM_MERGE;
    end else begin
      for (int p = 0; p < N_PAIRS; p++) mode_q[p] <= mode_d[p];
    end
  end

  generate
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_chk
      // R4
      smaller_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_a[p] && mode_q[p] == PM_MERGE) |->
          (a_head[p][KEY_W-1:0] <= b_head[p][KEY_W-1:0]));
      // R5
      tie_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_push[p] && mode_q[p] == PM_MERGE &&
         a_head[p][KEY_W-1:0] == b_head[p][KEY_W-1:0]) |-> pop_a[p]);
      // R6
      drain_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[p] == PM_A_ENDED) |-> !pop_a[p]);
      // R6
      drain_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[p] == PM_B_ENDED) |-> !pop_b[p]);
      // R7
      last_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_push[p] && push_rec[KEY_W]) |-> (mode_q[p] != PM_MERGE));
    end
  endgenerate

endmodule

// File: rtl/merge_level.sv
module merge_level import mtl_pkg::*; #(
  parameter int N_PAIRS    = 4,
  parameter int KEY_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter bit PIPE_SCHED = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*N_PAIRS-1:0]       in_valid,
  output logic [2*N_PAIRS-1:0]       in_ready,
  input  logic [2*N_PAIRS*KEY_W-1:0] in_key,
  input  logic [2*N_PAIRS-1:0]       in_last,
  output logic [N_PAIRS-1:0]         out_valid,
  input  logic [N_PAIRS-1:0]         out_ready,
  output logic [N_PAIRS*KEY_W-1:0]   out_key,
  output logic [N_PAIRS-1:0]         out_last
);

  localparam int REC_W = KEY_W + 1;
  localparam int IW    = idx_width(N_PAIRS);

  logic [REC_W-1:0]   a_head [N_PAIRS];
  logic [REC_W-1:0]   b_head [N_PAIRS];
  logic [REC_W-1:0]   o_head [N_PAIRS];
  logic [N_PAIRS-1:0] a_ne, b_ne, o_room, elig, pop_a, pop_b, o_push;
  logic [REC_W-1:0]   push_rec;
  logic               fire;
  logic [IW-1:0]      fire_idx;

  generate
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
      mtl_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_in_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid[2*p] && in_ready[2*p]),
        .din       ({in_last[2*p], in_key[2*p*KEY_W +: KEY_W]}),
        .pop       (pop_a[p]),
        .not_full  (in_ready[2*p]),
        .not_empty (a_ne[p]),
        .head      (a_head[p])
      );

      mtl_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_in_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid[2*p+1] && in_ready[2*p+1]),
        .din       ({in_last[2*p+1], in_key[(2*p+1)*KEY_W +: KEY_W]}),
        .pop       (pop_b[p]),
        .not_full  (in_ready[2*p+1]),
        .not_empty (b_ne[p]),
        .head      (b_head[p])
      );

      mtl_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (o_push[p]),
        .din       (push_rec),
        .pop       (out_valid[p] && out_ready[p]),
        .not_full  (o_room[p]),
        .not_empty (out_valid[p]),
        .head      (o_head[p])
      );

      assign out_last[p]                 = o_head[p][KEY_W];
      assign out_key[p*KEY_W +: KEY_W]   = o_head[p][KEY_W-1:0];

      // R11
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_push[p] |-> o_room[p]);
    end
  endgenerate

  mtl_sched #(.N(N_PAIRS), .PIPE_SCHED(PIPE_SCHED), .IW(IW)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .fire     (fire),
    .fire_idx (fire_idx)
  );

  mtl_merge_core #(.N_PAIRS(N_PAIRS), .KEY_W(KEY_W), .IW(IW), .REC_W(REC_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .fire_idx (fire_idx),
    .a_head   (a_head),
    .b_head   (b_head),
    .a_ne     (a_ne),
    .b_ne     (b_ne),
    .o_room   (o_room),
    .elig     (elig),
    .pop_a    (pop_a),
    .pop_b    (pop_b),
    .o_push   (o_push),
    .push_rec (push_rec)
  );

  // R8
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(o_push) <= 1);
  // R8
  pop_matches_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pop_a, pop_b}) == $countones(o_push));

endmodule

// File: tb/test_merge_level.sv
module test_merge_level;

  localparam int NP         = 4;
  localparam int NI         = 2 * NP;
  localparam int KW         = 32;
  localparam int DEP        = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n;

  logic [NI-1:0]    in_valid  [2];
  logic [NI*KW-1:0] in_key    [2];
  logic [NI-1:0]    in_last   [2];
  logic [NI-1:0]    in_ready  [2];
  logic [NP-1:0]    out_valid [2];
  logic [NP*KW-1:0] out_key   [2];
  logic [NP-1:0]    out_last  [2];
  logic [NP-1:0]    out_rdy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  merge_level #(.N_PAIRS(NP), .KEY_W(KW), .FIFO_DEPTH(DEP), .PIPE_SCHED(1'b0)) i_merge_level (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid[0]), .in_ready(in_ready[0]), .in_key(in_key[0]), .in_last(in_last[0]),
    .out_valid(out_valid[0]), .out_ready(out_rdy), .out_key(out_key[0]), .out_last(out_last[0])
  );

  merge_level #(.N_PAIRS(NP), .KEY_W(KW), .FIFO_DEPTH(DEP), .PIPE_SCHED(1'b1)) i_merge_level_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid[1]), .in_ready(in_ready[1]), .in_key(in_key[1]), .in_last(in_last[1]),
    .out_valid(out_valid[1]), .out_ready(out_rdy), .out_key(out_key[1]), .out_last(out_last[1])
  );

  // Reference model state: index 0 = combinational scheduler, 1 = registered.
  logic [KW:0] stim   [NI][$];
  int          spos   [2][NI];
  logic [KW:0] mq_in  [2][NI][$];
  logic [KW:0] mq_out [2][NP][$];
  int          pmode  [2][NP];   // 0 merge, 1 first side ended, 2 second side ended
  int          rr_last[2];
  bit          selv   [2];
  int          seli   [2];
  int          delivered[2][NP];
  int          expected [NP];
  logic [KW-1:0] prev_key[2][NP];
  bit          in_run [2][NP];

  int checks = 0;
  int errors = 0;

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chkw(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_elig(input int m, input int p);
    if (mq_out[m][p].size() >= DEP) return 1'b0;
    case (pmode[m][p])
      0:       return (mq_in[m][2*p].size() > 0) && (mq_in[m][2*p+1].size() > 0);
      1:       return mq_in[m][2*p+1].size() > 0;
      default: return mq_in[m][2*p].size() > 0;
    endcase
  endfunction

  task automatic step_model(input int m);
    bit el [NP];
    bit found, fv, take_a;
    int g, fi, md;
    logic [KW:0] rec;
    for (int p = 0; p < NP; p++) el[p] = m_elig(m, p);
    found = 1'b0;
    g = 0;
    for (int i = 1; i <= NP; i++) begin
      if (!found && el[(rr_last[m] + i) % NP]) begin
        found = 1'b1;
        g = (rr_last[m] + i) % NP;
      end
    end
    if (m == 0) begin
      fv = found;
      fi = g;
    end else begin
      fv = selv[m] && el[seli[m]];
      fi = seli[m];
      selv[m] = found;
      if (found) seli[m] = g;
    end
    if (found) rr_last[m] = g;
    for (int p = 0; p < NP; p++)
      if (mq_out[m][p].size() > 0 && out_rdy[p]) void'(mq_out[m][p].pop_front());
    for (int j = 0; j < NI; j++) begin
      if (in_valid[m][j] && mq_in[m][j].size() < DEP) begin
        mq_in[m][j].push_back(stim[j][spos[m][j]]);
        spos[m][j]++;
      end
    end
    if (fv) begin
      md = pmode[m][fi];
      if (md == 1)      take_a = 1'b0;
      else if (md == 2) take_a = 1'b1;
      else              take_a = (mq_in[m][2*fi][0][KW-1:0] <= mq_in[m][2*fi+1][0][KW-1:0]);
      rec = take_a ? mq_in[m][2*fi].pop_front() : mq_in[m][2*fi+1].pop_front();
      mq_out[m][fi].push_back({rec[KW] && (md != 0), rec[KW-1:0]});
      if (rec[KW]) pmode[m][fi] = (md == 0) ? (take_a ? 1 : 2) : 0;
    end
  endtask

  task automatic compare_all();
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < NI; j++)
        chk1("R2/R5/R8/R11 in_ready", in_ready[m][j], mq_in[m][j].size() < DEP);
      for (int p = 0; p < NP; p++) begin
        chk1("R3/R10 out_valid", out_valid[m][p], mq_out[m][p].size() > 0);
        if (mq_out[m][p].size() > 0) begin
          chkw("R4/R5/R6/R9 out_key", out_key[m][p*KW +: KW], mq_out[m][p][0][KW-1:0]);
          chk1("R6/R7 out_last", out_last[m][p], mq_out[m][p][0][KW]);
        end
      end
    end
  endtask

  task automatic drive_inputs(input int cyc);
    for (int p = 0; p < NP; p++) begin
      if (cyc >= 40 && cyc < 80) out_rdy[p] = 1'b0;
      else if (cyc < 40)         out_rdy[p] = ($urandom % 2) != 0;
      else                       out_rdy[p] = ($urandom % 8) != 0;
    end
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < NI; j++) begin
        if (spos[m][j] < stim[j].size() && ($urandom % 4) != 0) begin
          in_valid[m][j]            = 1'b1;
          in_key[m][j*KW +: KW]     = stim[j][spos[m][j]][KW-1:0];
          in_last[m][j]             = stim[j][spos[m][j]][KW];
        end else begin
          in_valid[m][j]            = 1'b0;
          in_key[m][j*KW +: KW]     = '0;
          in_last[m][j]             = 1'b0;
        end
      end
      // Handshakes at the coming edge, observed at the ports.
      for (int p = 0; p < NP; p++) begin
        if (out_valid[m][p] && out_rdy[p]) begin
          if (in_run[m][p])
            chk1("R4 merged run ascends", out_key[m][p*KW +: KW] >= prev_key[m][p], 1'b1);
          prev_key[m][p] = out_key[m][p*KW +: KW];
          in_run[m][p]   = !out_last[m][p];
          delivered[m][p]++;
        end
      end
    end
  endtask

  initial begin
    int cyc;
    bit done;
    logic [KW-1:0] k;
    int len;

    // Streams: equal run counts on both sides of a pair.
    for (int j = 0; j < NI; j++) begin
      for (int r = 0; r < 5; r++) begin
        len = 1 + int'($urandom % 4);
        if (j == 4)      k = 32'hFFFF_FF00;
        else if (j >= 6) k = 32'd100;
        else             k = 32'($urandom % 16);
        for (int i = 0; i < len; i++) begin
          if (j >= 6) k = k + 32'($urandom % 2);
          else        k = k + 32'($urandom % 5);
          stim[j].push_back({i == len - 1, k});
        end
      end
    end
    for (int p = 0; p < NP; p++) expected[p] = stim[2*p].size() + stim[2*p+1].size();
    for (int m = 0; m < 2; m++) begin
      rr_last[m] = NP - 1;
      selv[m]    = 1'b0;
      seli[m]    = 0;
      for (int j = 0; j < NI; j++) spos[m][j] = 0;
      for (int p = 0; p < NP; p++) begin
        pmode[m][p]     = 0;
        delivered[m][p] = 0;
        prev_key[m][p]  = '0;
        in_run[m][p]    = 1'b0;
      end
      in_valid[m] = '0;
      in_key[m]   = '0;
      in_last[m]  = '0;
    end
    out_rdy = '0;
    rst_n   = 1'b0;

    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < NI; j++) chk1("R1 in_ready in reset", in_ready[m][j], 1'b1);
      for (int p = 0; p < NP; p++) chk1("R1 out_valid in reset", out_valid[m][p], 1'b0);
    end
    rst_n = 1'b1;

    cyc  = 0;
    done = 1'b0;
    while (!done && cyc < WATCHDOG) begin
      drive_inputs(cyc);
      @(posedge clk);
      step_model(0);
      step_model(1);
      @(negedge clk);
      compare_all();
      cyc++;
      done = 1'b1;
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < NP; p++)
          if (delivered[m][p] != expected[p] || out_valid[m][p]) done = 1'b0;
    end

    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected<%0d cycles", cyc, WATCHDOG);
    end
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < NP; p++)
        chkw("R8 records delivered per pair", 32'(delivered[m][p]), 32'(expected[p]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule